// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog for a system that must reset itself when software stops responding. A down-counter runs once the watchdog is armed. Software prevents a reset by writing a fixed key to a restart word before the counter runs out. If the counter reaches zero, the block raises a system reset output for a fixed number of cycles. It then reloads and keeps watching. Once armed, the watchdog cannot be disarmed by software. Only a reset of the block itself returns it to the idle state.

Software reaches the block through a plain 32-bit word bus with four word slots: control, period selection, live count and restart key. The period selection holds two 4-bit indices. Each index `i` selects a length of 2^(BASE_EXP+i) clock cycles, and BASE_EXP is 16 by default. One index applies only to the first countdown after arming. The other applies to every later reload.

Top module: `lockable_wdt`

## Requirements
- R1: After block reset the control word reads 0, the period word reads 0, the count word reads 2^BASE_EXP and `sysResetOut` is low.
- R2: Writing a word with bit 0 set to slot 0 (byte offset 0x0) arms the watchdog, and control bit 0 then reads 1. A later write of 0 to that slot leaves it at 1.
- R3: The period word at slot 1 (offset 0x4) stores `busWdata[7:0]`. Bits [3:0] are the normal period index and bits [7:4] are the first-period index. Index `i` means a reload of 2^(BASE_EXP+i) cycles.
- R4: While the watchdog is not armed, the count word holds 2^(BASE_EXP + first-period index) one cycle after that field changes. Restart writes are ignored and `sysResetOut` stays low.
- R5: The clock edge that arms the block loads the first-period length. Each later edge lowers the count by one.
- R6: While armed and not in a reset pulse, writing exactly 0x00000076 to slot 3 (offset 0xC) loads 2^(BASE_EXP + normal index). Any other value leaves the count unchanged.
- R7: When the armed count reads 0, `sysResetOut` rises on the next edge. It stays high for exactly PULSE_LEN (8) cycles while the count holds 0. On the edge that lowers it, the count reloads with the normal length and counting continues.
- R8: Restart writes made while `sysResetOut` is high have no effect on the count or on the pulse length.
- R9: Writes to the count word (slot 2, offset 0x8) have no effect. The restart slot reads 0. Period bits [31:8] and control bits [31:1] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous block reset |
| busSel | input | 1 | Bus access valid |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 4 | Byte address; bits [3:2] pick the slot |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational from busAddr |
| sysResetOut | output | 1 | System reset request, high during an expiry pulse |

## Verification
The read data is combinational, so a read reflects the state left by the most recent rising edge. A write driven before an edge is visible at the next falling edge. One exception is the count after a first-period change while idle: it appears one cycle later, because the counter loads from the registered field. The reset pulse rises one edge after the count reads zero, lasts eight edges, and the reload shows on the edge that ends it. The bench drives every access on a falling edge and places each expected value in a queue against that falling edge. A monitor compares the queued values a moment later, with the expiry cycle worked out by counting edges from the last reload.

// File: rtl/lwdt_pkg.sv
package lwdt_pkg;
  // Word slots selected by busAddr[3:2]
  localparam logic [1:0] SLOT_CTRL  = 2'd0;
  localparam logic [1:0] SLOT_RANGE = 2'd1;
  localparam logic [1:0] SLOT_COUNT = 2'd2;
  localparam logic [1:0] SLOT_KICK  = 2'd3;

  localparam logic [31:0] KICK_KEY = 32'h0000_0076;
  localparam int          IDX_COUNT = 16;

  // Commands from control to the counter datapath
  typedef struct packed {
    logic loadInit;
    logic loadNormal;
    logic countDown;
  } cnt_strobe_t;
endpackage

// File: rtl/lwdt_datapath.sv
module lwdt_datapath
  import lwdt_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + IDX_COUNT
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strobes,
  input  logic [3:0]       initIdx,
  input  logic [3:0]       periodIdx,
  output logic [CNT_W-1:0] countVal,
  output logic             countZero
);
  localparam logic [CNT_W-1:0] RESET_LOAD = CNT_W'(1) << BASE_EXP;

  logic [CNT_W-1:0] reloadTbl [IDX_COUNT];

  for (genvar g = 0; g < IDX_COUNT; g++) begin : g_reload
    assign reloadTbl[g] = CNT_W'(1) << (BASE_EXP + g);
  end

  logic [CNT_W-1:0] countReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countReg <= RESET_LOAD;
    end else if (strobes.loadInit) begin
      countReg <= reloadTbl[initIdx];
    end else if (strobes.loadNormal) begin
      countReg <= reloadTbl[periodIdx];
    end else if (strobes.countDown) begin
      countReg <= countReg - CNT_W'(1);
    end
  end

  assign countVal  = countReg;
  assign countZero = (countReg == '0);

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countDown |=> countReg == $past(countReg) - CNT_W'(1)); // R5
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    strobes.countDown |-> countReg != '0); // R7
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobes.loadInit, strobes.loadNormal, strobes.countDown}) <= 1); // R5
endmodule

// File: rtl/lwdt_ctrl.sv
module lwdt_ctrl
  import lwdt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int PULSE_LEN = 8,
  parameter int PULSE_W   = $clog2(PULSE_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busSel,
  input  logic             busWrite,
  input  logic [3:0]       busAddr,
  input  logic [31:0]      busWdata,
  output logic [31:0]      busRdata,
  input  logic [CNT_W-1:0] countVal,
  input  logic             countZero,
  output cnt_strobe_t      strobes,
  output logic [3:0]       initIdx,
  output logic [3:0]       periodIdx,
  output logic             pulseOut
);
  logic [1:0]         slot;
  logic               wrHit;
  logic               kickHit;
  logic               startPulse;
  logic               enReg;
  logic [7:0]         rangeReg;
  logic               pulseActive;
  logic [PULSE_W-1:0] pulseLeft;

  assign slot    = busAddr[3:2];
  assign wrHit   = busSel && busWrite;
  assign kickHit = wrHit && (slot == SLOT_KICK) && (busWdata == KICK_KEY);
  assign startPulse = enReg && !pulseActive && !kickHit && countZero;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg       <= 1'b0;
      rangeReg    <= '0;
      pulseActive <= 1'b0;
      pulseLeft   <= '0;
    end else begin
      if (wrHit && slot == SLOT_CTRL && busWdata[0]) begin
        enReg <= 1'b1;
      end
      if (wrHit && slot == SLOT_RANGE) begin
        rangeReg <= busWdata[7:0];
      end
      if (pulseActive) begin
        if (pulseLeft == '0) begin
          pulseActive <= 1'b0;
        end else begin
          pulseLeft <= pulseLeft - PULSE_W'(1);
        end
      end else if (startPulse) begin
        pulseActive <= 1'b1;
        pulseLeft   <= PULSE_W'(PULSE_LEN - 1);
      end
    end
  end

  always_comb begin
    strobes = '0;
    if (!enReg) begin
      strobes.loadInit = 1'b1;
    end else if (pulseActive) begin
      strobes.loadNormal = (pulseLeft == '0);
    end else if (kickHit) begin
      strobes.loadNormal = 1'b1;
    end else if (!countZero) begin
      strobes.countDown = 1'b1;
    end
  end

  always_comb begin
    case (slot)
      SLOT_CTRL:  busRdata = {31'd0, enReg};
      SLOT_RANGE: busRdata = {24'd0, rangeReg};
      SLOT_COUNT: busRdata = 32'(countVal);
      default:    busRdata = '0;
    endcase
  end

  assign initIdx   = rangeReg[7:4];
  assign periodIdx = rangeReg[3:0];
  assign pulseOut  = pulseActive;

  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    enReg |=> enReg); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enReg |-> !pulseActive); // R4
  AST_PULSE_BEGIN: assert property (@(posedge clk) disable iff (!rstN)
    (enReg && !pulseActive && countZero && !kickHit) |=> pulseActive); // R7
  AST_PULSE_IGNORES_KICK: assert property (@(posedge clk) disable iff (!rstN)
    (pulseActive && pulseLeft != '0) |=> pulseActive && countZero); // R8
endmodule

// File: rtl/lockable_wdt.sv
module lockable_wdt
  import lwdt_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWrite,
  input  logic [3:0]  busAddr,
  input  logic [31:0] busWdata,
  output logic [31:0] busRdata,
  output logic        sysResetOut
);
  localparam int CNT_W = BASE_EXP + IDX_COUNT;

  cnt_strobe_t      strobes;
  logic [3:0]       initIdx;
  logic [3:0]       periodIdx;
  logic [CNT_W-1:0] countVal;
  logic             countZero;

  lwdt_ctrl #(
    .CNT_W     (CNT_W),
    .PULSE_LEN (PULSE_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWrite  (busWrite),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .countVal  (countVal),
    .countZero (countZero),
    .strobes   (strobes),
    .initIdx   (initIdx),
    .periodIdx (periodIdx),
    .pulseOut  (sysResetOut)
  );

  lwdt_datapath #(
    .BASE_EXP (BASE_EXP),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .initIdx   (initIdx),
    .periodIdx (periodIdx),
    .countVal  (countVal),
    .countZero (countZero)
  );
endmodule

// File: tb/lockable_wdt_tb.sv
module lockable_wdt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BASE_EXP   = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        sysResetOut;

  lockable_wdt #(.BASE_EXP(BASE_EXP), .PULSE_LEN(8)) u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .sysResetOut(sysResetOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    bit          isRst;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // Monitor: compares queued expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        exp_item_t it;
        it = expQ.pop_front();
        checks++;
        if (it.isRst) begin
          if (sysResetOut !== it.exp[0]) begin
            errors++;
            $display("FAIL %s: sysResetOut actual %0b expected %0b", it.tag, sysResetOut, it.exp[0]);
          end
        end else if (busRdata !== it.exp) begin
          errors++;
          $display("FAIL %s: read 0x%0h actual 0x%0h expected 0x%0h", it.tag, it.addr, busRdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
  endtask

  task automatic rdExp(input logic [3:0] a, input logic [31:0] e, input string tag);
    exp_item_t it;
    @(negedge clk);
    busSel = 1'b1; busWrite = 1'b0; busAddr = a; busWdata = '0;
    it.isRst = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Same falling edge as the preceding rdExp
  task automatic rstExp(input bit e, input string tag);
    exp_item_t it;
    it.isRst = 1'b1; it.addr = '0; it.exp = {31'd0, e}; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      busSel = 1'b0; busWrite = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdExp(4'h0, 32'd0, "R1 control");
    rstExp(1'b0, "R1 reset low");
    rdExp(4'h4, 32'd0, "R1 period word");
    rdExp(4'h8, 32'd16, "R1 count");
    // R3/R9: first index 2, normal index 1, upper bits dropped
    wr(4'h4, 32'hFFFF_FF21);
    rdExp(4'h4, 32'h21, "R3 R9 period word");
    rdExp(4'h8, 32'd64, "R4 idle count follows first index");
    // R4: restart ignored while idle
    wr(4'hC, 32'h76);
    rdExp(4'h8, 32'd64, "R4 idle restart ignored");
    rstExp(1'b0, "R4 idle reset low");
    // R9: count write ignored
    wr(4'h8, 32'd5);
    rdExp(4'h8, 32'd64, "R9 count write ignored");
    rdExp(4'hC, 32'd0, "R9 restart slot reads 0");
    // R5: arm
    wr(4'h0, 32'hFFFF_FFFF);
    rdExp(4'h0, 32'd1, "R2 armed");
    rdExp(4'h8, 32'd63, "R5 first decrement");
    rdExp(4'h8, 32'd62, "R5 second decrement");
    // R2: cannot disarm (count 61 at this edge)
    wr(4'h0, 32'd0);
    rdExp(4'h0, 32'd1, "R2 clear ignored");
    rdExp(4'h8, 32'd59, "R5 still counting");
    // R6: wrong key
    wr(4'hC, 32'h75);
    rdExp(4'h8, 32'd57, "R6 wrong key ignored");
    // R6: right key, normal index 1 -> 32
    wr(4'hC, 32'h76);
    rdExp(4'h8, 32'd32, "R6 key reload");
    // normal index 0 for later reloads; count 30 after this write edge
    wr(4'h4, 32'd0);
    idle(29);
    rdExp(4'h8, 32'd1, "R5 count nearly out");
    rdExp(4'h8, 32'd0, "R7 count zero");
    rstExp(1'b0, "R7 reset not yet");
    rdExp(4'h8, 32'd0, "R7 pulse held count");
    rstExp(1'b1, "R7 pulse start");
    wr(4'hC, 32'h76);
    rdExp(4'h8, 32'd0, "R8 kick in pulse ignored");
    rstExp(1'b1, "R8 pulse continues");
    idle(4);
    rdExp(4'h8, 32'd0, "R7 last pulse cycle count");
    rstExp(1'b1, "R7 eighth pulse cycle");
    rdExp(4'h8, 32'd16, "R7 reload normal length");
    rstExp(1'b0, "R7 pulse ended");
    rdExp(4'h8, 32'd15, "R7 counting resumes");
    rdExp(4'hC, 32'd0, "R9 restart slot reads 0 armed");
    rdExp(4'h8, 32'd13, "R7 counting");
    idle(12);
    rdExp(4'h8, 32'd0, "R7 second expiry zero");
    rstExp(1'b0, "R7 second expiry not yet");
    rdExp(4'h8, 32'd0, "R7 second expiry held");
    rstExp(1'b1, "R7 second pulse");
    idle(3);
    finished = 1'b1;
  end

  initial begin
    fork
      begin
        wait (finished);
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not complete, actual hung expected done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule